// File: doc/BRIEF.md
# Mixed-Sign Byte Pair Multiply-Accumulate Unit

This block is a SIMD datapath stage for a vector execution pipe. It takes two 256-bit operands. Every byte of the first operand is treated as an unsigned value. The byte in the same position of the second operand is treated as a signed two's-complement value. The two bytes are multiplied. The two products that fall in each 16-bit word are then added, and the sum is clamped into the signed 16-bit range. The result is one 16-bit word per byte pair, packed in the same word positions as the inputs.

A two-bit width selector picks one of three behaviours. Full width computes all sixteen result words. The two half-width forms compute only the low eight words and differ in what happens to destination bits 255:128. The merge form copies those bits from the previous destination value, which is a block input. The clearing form writes them as zero. The result goes through a single register stage qualified by a valid strobe. A per-word flag vector comes out alongside the result and marks each word that was clamped.

Top module: `pairsum_unit`

## Requirements
- R1: Each byte of `opa` is read as unsigned 0..255 and each byte of `opb` as signed -128..127, so `opa` byte 0xFF times `opb` byte 0xFF is -255, and 0x80 times 0x01 is +128.
- R2: Result word k (bits 16k+15:16k) is the sum of the products of byte 2k (bits 16k+7:16k) and byte 2k+1 (bits 16k+15:16k+8) of the two operands.
- R3: A pair sum above 32767 produces 0x7FFF in that word.
- R4: A pair sum below -32768 produces 0x8000 in that word.
- R5: Sums of exactly 32767 and exactly -32768 pass through unclamped, and their flag stays clear.
- R6: With `in_mode` = 2'b00, all sixteen words are computed across the full 256-bit result.
- R7: With `in_mode` = 2'b01, words 0..7 are computed, result bits 255:128 equal `old_dst` bits 255:128, and flags 15..8 are zero, whatever the upper operand bytes hold.
- R8: With `in_mode` = 2'b10, words 0..7 are computed, and result bits 255:128 and flags 15..8 are zero.
- R9: `in_mode` = 2'b11 behaves exactly like 2'b10.
- R10: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. A synchronous active-high `rst` clears `out_valid`, `out_data` and `out_sat`.
- R11: `out_sat` bit k is set exactly when word k was computed and clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| in_mode | input | 2 | Width select: 00 full, 01 half with merge, 10/11 half with clear |
| opa | input | 256 | Unsigned byte operand |
| opb | input | 256 | Signed byte operand |
| old_dst | input | 256 | Previous destination value, used for merging |
| out_valid | output | 1 | Result valid |
| out_data | output | 256 | Packed saturated signed words |
| out_sat | output | 16 | Per-word clamp flags |

## Verification
The clocked properties assume that `rst` is held high through the first clock edge, that `in_valid` is never unknown after reset, and that `in_mode` and `old_dst` are stable and known in any cycle where `in_valid` is high. The bench drives every input from a defined value at time zero and keeps reset asserted for several cycles. It changes inputs only on the falling clock edge and keeps `in_mode` to values it has set explicitly. Operands are either directed corner patterns (clamp thresholds, exact range limits, alternating clamped words) or fully random 256-bit values. Random values are safe here, because the properties hold for any data.

// File: rtl/pairsum_pkg.sv
package pairsum_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    // unsigned byte widened by one sign bit, times signed byte, plus one bit of sum growth
    localparam int PROD_W = 2 * BYTE_W + 2;

    localparam logic signed [PROD_W-1:0] WORD_MAX = PROD_W'(2 ** (WORD_W - 1) - 1);
    localparam logic signed [PROD_W-1:0] WORD_MIN = ~WORD_MAX;

    typedef enum logic [1:0] {
        VM_FULL    = 2'b00,
        VM_LO_KEEP = 2'b01,
        VM_LO_ZERO = 2'b10,
        VM_LO_ALT  = 2'b11
    } vmode_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sat;
    } lane_res_t;

    function automatic lane_res_t clamp_word(input logic signed [PROD_W-1:0] s);
        lane_res_t r;
        if (s > WORD_MAX) begin
            r.word = {1'b0, {(WORD_W-1){1'b1}}};
            r.sat  = 1'b1;
        end else if (s < WORD_MIN) begin
            r.word = {1'b1, {(WORD_W-1){1'b0}}};
            r.sat  = 1'b1;
        end else begin
            r.word = s[WORD_W-1:0];
            r.sat  = 1'b0;
        end
        return r;
    endfunction

    function automatic logic upper_kept(input vmode_e m);
        return m == VM_LO_KEEP;
    endfunction

    function automatic logic upper_full(input vmode_e m);
        return m == VM_FULL;
    endfunction

endpackage

// File: rtl/pairsum_lane.sv
module pairsum_lane
    import pairsum_pkg::*;
(
    input  logic [WORD_W-1:0] a_pair,
    input  logic [WORD_W-1:0] b_pair,
    output lane_res_t         res
);

    logic signed [PROD_W-1:0] prod [2];
    logic signed [PROD_W-1:0] pair_sum;

    for (genvar j = 0; j < 2; j++) begin : g_byte
        logic signed [BYTE_W:0] ua;
        logic signed [BYTE_W:0] sb;
        always_comb begin
            ua      = {1'b0, a_pair[j*BYTE_W +: BYTE_W]};
            sb      = {b_pair[j*BYTE_W + BYTE_W - 1], b_pair[j*BYTE_W +: BYTE_W]};
            prod[j] = PROD_W'(ua) * PROD_W'(sb);
        end
    end

    always_comb begin
        pair_sum = prod[0] + prod[1];
        res      = clamp_word(pair_sum);
    end

endmodule

// File: rtl/pairsum_select.sv
module pairsum_select
    import pairsum_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int HALF_WORDS = NUM_WORDS / 2,
    localparam int HALF_W = HALF_WORDS * WORD_W
) (
    input  vmode_e                             mode,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]   lane_word,
    input  logic [NUM_WORDS-1:0]               lane_sat,
    input  logic [HALF_W-1:0]                  old_upper,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]   sel_word,
    output logic [NUM_WORDS-1:0]               sel_sat
);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        if (k < HALF_WORDS) begin : g_low
            always_comb begin
                sel_word[k] = lane_word[k];
                sel_sat[k]  = lane_sat[k];
            end
        end else begin : g_high
            always_comb begin
                if (upper_full(mode)) begin
                    sel_word[k] = lane_word[k];
                    sel_sat[k]  = lane_sat[k];
                end else if (upper_kept(mode)) begin
                    sel_word[k] = old_upper[(k-HALF_WORDS)*WORD_W +: WORD_W];
                    sel_sat[k]  = 1'b0;
                end else begin
                    sel_word[k] = '0;
                    sel_sat[k]  = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pairsum_stage.sv
module pairsum_stage #(
    parameter int DATA_W = 256,
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [FLAG_W-1:0] in_flags,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [FLAG_W-1:0] out_flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= in_data;
                out_flags <= in_flags;
            end
        end
    end

endmodule

// File: rtl/pairsum_unit.sv
module pairsum_unit
    import pairsum_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int VEC_W = NUM_WORDS * WORD_W,
    localparam int HALF_W = (NUM_WORDS / 2) * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic [VEC_W-1:0] old_dst,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic [NUM_WORDS-1:0] out_sat
);

    vmode_e mode;
    logic [NUM_WORDS-1:0][WORD_W-1:0] lane_word;
    logic [NUM_WORDS-1:0]             lane_sat;
    logic [NUM_WORDS-1:0][WORD_W-1:0] sel_word;
    logic [NUM_WORDS-1:0]             sel_sat;
    logic                             unused_old_lo;

    assign mode          = vmode_e'(in_mode);
    assign unused_old_lo = ^old_dst[HALF_W-1:0];

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_lane
        lane_res_t res;
        pairsum_lane i_lane (
            .a_pair (opa[k*WORD_W +: WORD_W]),
            .b_pair (opb[k*WORD_W +: WORD_W]),
            .res    (res)
        );
        assign lane_word[k] = res.word;
        assign lane_sat[k]  = res.sat;
    end

    pairsum_select #(.NUM_WORDS(NUM_WORDS)) i_select (
        .mode      (mode),
        .lane_word (lane_word),
        .lane_sat  (lane_sat),
        .old_upper (old_dst[VEC_W-1:HALF_W]),
        .sel_word  (sel_word),
        .sel_sat   (sel_sat)
    );

    pairsum_stage #(.DATA_W(VEC_W), .FLAG_W(NUM_WORDS)) i_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (sel_word),
        .in_flags  (sel_sat),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_flags (out_sat)
    );

    // R10: reset empties the output stage
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && out_sat == '0));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_keep_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01) |=>
            (out_data[VEC_W-1:HALF_W] == $past(old_dst[VEC_W-1:HALF_W])
             && out_sat[NUM_WORDS-1:NUM_WORDS/2] == '0));

    // R8 and R9: both clearing encodings zero the upper half
    p_zero_upper_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[1]) |=>
            (out_data[VEC_W-1:HALF_W] == '0 && out_sat[NUM_WORDS-1:NUM_WORDS/2] == '0));

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_chk
        // R11: a flagged word holds one of the two clamp limits (R3, R4)
        p_flag_limit_r11: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_sat[k]) |->
                (out_data[k*WORD_W +: WORD_W] == 16'h7FFF
                 || out_data[k*WORD_W +: WORD_W] == 16'h8000));
    end

endmodule

// File: tb/test_pairsum_unit.sv
module test_pairsum_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;
    localparam int VW = NW * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic [VW-1:0] opa = '0;
    logic [VW-1:0] opb = '0;
    logic [VW-1:0] old_dst = '0;
    logic          out_valid;
    logic [VW-1:0] out_data;
    logic [NW-1:0] out_sat;

    int checks = 0;
    int errors = 0;

    pairsum_unit i_pairsum_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .opa(opa), .opb(opb), .old_dst(old_dst),
        .out_valid(out_valid), .out_data(out_data), .out_sat(out_sat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void model(input logic [1:0] m, input logic [VW-1:0] a,
                                  input logic [VW-1:0] b, input logic [VW-1:0] old,
                                  output logic [VW-1:0] d, output logic [NW-1:0] s);
        for (int k = 0; k < NW; k++) begin
            int sum = 0;
            for (int j = 0; j < 2; j++) begin
                logic [7:0] ab = a[16*k + 8*j +: 8];
                logic [7:0] bb = b[16*k + 8*j +: 8];
                int ua = int'(ab);
                int sb = int'($signed(bb));
                sum += ua * sb;
            end
            s[k] = 1'b0;
            if (sum > 32767) begin d[16*k +: 16] = 16'h7FFF; s[k] = 1'b1; end
            else if (sum < -32768) begin d[16*k +: 16] = 16'h8000; s[k] = 1'b1; end
            else d[16*k +: 16] = sum[15:0];
            if (k >= NW/2 && m != 2'b00) begin
                s[k] = 1'b0;
                d[16*k +: 16] = (m == 2'b01) ? old[16*k +: 16] : 16'h0000;
            end
        end
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one operation at the falling edge, compare one cycle later
    task automatic run_op(input string req, input logic [1:0] m, input logic [VW-1:0] a,
                          input logic [VW-1:0] b, input logic [VW-1:0] old);
        logic [VW-1:0] ed;
        logic [NW-1:0] es;
        model(m, a, b, old, ed, es);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; opa = a; opb = b; old_dst = old;
        @(negedge clk);
        in_valid = 1'b0;
        check_val(req, "out_valid", VW'(out_valid), VW'(1'b1));
        check_val(req, "out_data", out_data, ed);
        check_val(req, "out_sat", VW'(out_sat), VW'(es));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_val("R10", "reset out_valid", VW'(out_valid), '0);
        check_val("R10", "reset out_data", out_data, '0);
        check_val("R10", "reset out_sat", VW'(out_sat), '0);
    endtask

    task automatic t_signedness();
        run_op("R1", 2'b00, {32{8'hFF}}, {32{8'hFF}}, '0);
        check_val("R1", "0xFF*0xFF pair", VW'(out_data[15:0]), VW'(16'hFE02));
        run_op("R1", 2'b00, {32{8'h80}}, {32{8'h01}}, '0);
        check_val("R1", "0x80*0x01 pair", VW'(out_data[15:0]), VW'(16'h0100));
    endtask

    task automatic t_pair_order();
        logic [VW-1:0] a;
        for (int i = 0; i < VW/8; i++) a[8*i +: 8] = 8'(i + 1);
        run_op("R2", 2'b00, a, {32{8'h01}}, '0);
        check_val("R2", "word 5", VW'(out_data[16*5 +: 16]), VW'(16'd23));
        run_op("R2", 2'b00, {{(VW-16){1'b0}}, 16'h0205}, {{(VW-16){1'b0}}, 16'hFD03}, '0);
        check_val("R2", "word 0 mixed", VW'(out_data[15:0]), VW'(16'd9));
    endtask

    task automatic t_sat();
        run_op("R3", 2'b00, {32{8'hFF}}, {32{8'h7F}}, '0);
        check_val("R3", "all 7FFF", out_data, {16{16'h7FFF}});
        run_op("R4", 2'b00, {32{8'hFF}}, {32{8'h80}}, '0);
        check_val("R4", "all 8000", out_data, {16{16'h8000}});
    endtask

    task automatic t_boundary();
        run_op("R5", 2'b00, {16{16'hFFBF}}, {16{16'h7F02}}, '0);
        check_val("R5", "exact max flags", VW'(out_sat), '0);
        check_val("R5", "exact max word", VW'(out_data[15:0]), VW'(16'h7FFF));
        run_op("R5", 2'b00, {16{16'hFF01}}, {16{16'h8080}}, '0);
        check_val("R5", "exact min flags", VW'(out_sat), '0);
        check_val("R5", "exact min word", VW'(out_data[15:0]), VW'(16'h8000));
    endtask

    task automatic t_flags();
        run_op("R11", 2'b00, {32{8'hFF}}, {8{32'h0101_7F7F}}, '0);
        check_val("R11", "alternating flags", VW'(out_sat), VW'(16'h5555));
    endtask

    task automatic t_full_random();
        for (int i = 0; i < 4; i++) run_op("R6", 2'b00, rand_vec(), rand_vec(), rand_vec());
    endtask

    task automatic t_modes();
        for (int i = 0; i < 3; i++) run_op("R7", 2'b01, rand_vec(), rand_vec(), rand_vec());
        run_op("R7", 2'b01, {32{8'hFF}}, {32{8'h80}}, rand_vec());
        for (int i = 0; i < 2; i++) run_op("R8", 2'b10, rand_vec(), rand_vec(), rand_vec());
        run_op("R8", 2'b10, {32{8'hFF}}, {32{8'h7F}}, {VW{1'b1}});
        run_op("R9", 2'b11, {32{8'hFF}}, {32{8'h80}}, {VW{1'b1}});
        run_op("R9", 2'b11, rand_vec(), rand_vec(), rand_vec());
    endtask

    task automatic t_timing();
        logic [VW-1:0] a1 = rand_vec(), b1 = rand_vec(), a2 = rand_vec(), b2 = rand_vec();
        logic [VW-1:0] e1, e2;
        logic [NW-1:0] s1, s2;
        model(2'b00, a1, b1, '0, e1, s1);
        model(2'b00, a2, b2, '0, e2, s2);
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b00; opa = a1; opb = b1; old_dst = '0;
        @(negedge clk);
        check_val("R10", "first of pair valid", VW'(out_valid), VW'(1'b1));
        check_val("R10", "first of pair data", out_data, e1);
        opa = a2; opb = b2;
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R10", "second of pair data", out_data, e2);
        @(negedge clk);
        check_val("R10", "bubble valid low", VW'(out_valid), '0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_val("R10", "mid-run reset valid", VW'(out_valid), '0);
        check_val("R10", "mid-run reset data", out_data, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_signedness();
        t_pair_order();
        t_sat();
        t_boundary();
        t_flags();
        t_full_random();
        t_modes();
        t_timing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule